// File: doc/BRIEF.md
# Masked-Carry Counter Block Generator

This block supplies the successive 128-bit counter blocks that a counter-style block cipher mode encrypts to make keystream. Software or a sequencer stages an initial block as 32-bit words, then pulses a start strobe together with a mode and a width code. From then on, each advance request steps the block by one. The carry is kept inside a selected low-order field, so the bits above that field keep their loaded value. When the field is all ones, the next step rolls it to zero.

Three counting variants are selected by a 2-bit mode input. In general counter mode, a 2-bit width code picks the field size. Integer counter mode always counts in a fixed 16-bit field. Galois mode always counts in a 32-bit field and limits how many blocks may come from one initial value. The cipher core and the keystream XOR sit outside this block.

Top module: `ctrblk_gen`

## Requirements
- R1: After reset, blk_o is zero and valid_o, wrap_o and err_o are low.
- R2: A write with iv_wr_i stores iv_data_i into staged word iv_idx_i, where word 0 is bits 31:0 and word 3 is bits 127:96. Writing the word does not change blk_o. The cycle after start_i, blk_o holds the staged block, valid_o is high, and wrap_o and err_o are low.
- R3: With mode_i = 0, an advance increments a field that wsel_i selects: code 0 gives 32 bits, code 1 gives 64 bits, code 2 gives 128 bits. The new block appears the cycle after the advance.
- R4: With mode_i = 0 and wsel_i = 3 (192 bits), the whole 128-bit block increments.
- R5: With mode_i = 1, the field is bits 15:0 for any wsel_i.
- R6: With mode_i = 2, the field is bits 31:0 for any wsel_i.
- R7: An advance never alters any bit above the active field. The field wraps from all ones to zero.
- R8: wrap_o is high for exactly the one cycle in which blk_o shows a field that has just rolled from all ones to zero. In every other cycle wrap_o is low.
- R9: In mode 2, the block loaded by start counts as the first block, and GAL_LIMIT blocks may be presented (4294967294 by default). An advance requested after that raises err_o and leaves blk_o unchanged. err_o stays high until the next start_i.
- R10: adv_i has no effect while valid_o is low.
- R11: When start_i and adv_i are both high in the same cycle, start wins: the cycle after, blk_o shows the staged block and has not been incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iv_wr_i | input | 1 | Write strobe for one staged word |
| iv_idx_i | input | 2 | Index of the staged word (0 = least significant) |
| iv_data_i | input | 32 | Word data |
| mode_i | input | 2 | 0 general, 1 integer 16-bit, 2 Galois 32-bit, 3 same as 0 |
| wsel_i | input | 2 | Width code for mode 0 |
| start_i | input | 1 | Load the staged block and capture mode and width |
| adv_i | input | 1 | Advance request |
| blk_o | output | 128 | Current counter block |
| valid_o | output | 1 | blk_o holds a block of the current stream |
| wrap_o | output | 1 | Field rolled over on the last step |
| err_o | output | 1 | Galois block limit exceeded |

## Verification
The bound checker checks four things every cycle. An accepted step leaves all bits outside the active field unchanged. A wrap pulse only comes with a zero field. The error flag stays set until a start. The block holds while no stream is active. It also checks that a start always yields a valid block with no flags set.

Some results only the bench's scenarios can show, because they need arithmetic expected values. These are the field size for each mode and width code, the exact increment value, the wrap timing across the all-ones boundary, the exact position of the Galois limit, and start winning over a same-cycle advance. The bench builds the design with a small Galois limit so that limit can be reached.

// File: rtl/ctrblk_pkg.sv
package ctrblk_pkg;
   typedef enum logic [1:0] {
      CTRM_GEN = 2'd0,
      CTRM_INT = 2'd1,
      CTRM_GAL = 2'd2,
      CTRM_ALT = 2'd3
   } ctr_mode_e;

   typedef struct packed {
      ctr_mode_e  mode;
      logic [1:0] wsel;
   } ctr_cfg_t;
endpackage

// File: rtl/ctrblk_iv_stage.sv
module ctrblk_iv_stage #(
   parameter int BLK_W  = 128,
   parameter int WORD_W = 32,
   localparam int NWORDS = BLK_W / WORD_W,
   localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [BLK_W-1:0]  iv_o
);
   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_i && (idx_i == IDX_W'(w)))
            word_q <= data_i;
      end
      assign iv_o[w*WORD_W +: WORD_W] = word_q;
   end
endmodule

// File: rtl/ctrblk_width_sel.sv
module ctrblk_width_sel
   import ctrblk_pkg::*;
#(
   parameter int BLK_W = 128,
   parameter int CW0   = 32,
   parameter int CW1   = 64,
   parameter int CW2   = 128,
   parameter int CW3   = 192,
   parameter int INT_W = 16,
   parameter int GAL_W = 32,
   localparam int NW_W = $clog2(BLK_W + 1) + 1
) (
   input  ctr_cfg_t         cfg_i,
   output logic [BLK_W-1:0] mask_o
);
   logic [NW_W-1:0] width_w;

   function automatic logic [NW_W-1:0] clip(input int n);
      return (n > BLK_W) ? NW_W'(BLK_W) : NW_W'(n);
   endfunction

   always_comb begin
      unique case (cfg_i.mode)
         CTRM_INT: width_w = clip(INT_W);
         CTRM_GAL: width_w = clip(GAL_W);
         default: begin
            unique case (cfg_i.wsel)
               2'd0:    width_w = clip(CW0);
               2'd1:    width_w = clip(CW1);
               2'd2:    width_w = clip(CW2);
               default: width_w = clip(CW3);
            endcase
         end
      endcase
   end

   for (genvar b = 0; b < BLK_W; b++) begin : g_bit
      assign mask_o[b] = (NW_W'(b) < width_w);
   end
endmodule

// File: rtl/ctrblk_incr.sv
module ctrblk_incr #(
   parameter int BLK_W = 128
) (
   input  logic [BLK_W-1:0] cur_i,
   input  logic [BLK_W-1:0] mask_i,
   output logic [BLK_W-1:0] nxt_o,
   output logic             roll_o
);
   logic [BLK_W-1:0] sum_w;

   always_comb begin
      sum_w  = cur_i + BLK_W'(1);
      nxt_o  = (cur_i & ~mask_i) | (sum_w & mask_i);
      roll_o = &(cur_i | ~mask_i);
   end
endmodule

// File: rtl/ctrblk_limit.sv
module ctrblk_limit #(
   parameter longint unsigned LIMIT = 64'd4294967294,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic step_i,
   output logic full_o,
   output logic err_o
);
   logic [CNT_W-1:0] cnt_q;

   assign full_o = (cnt_q == CNT_W'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_o <= 1'b0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(1);
         err_o <= 1'b0;
      end else if (step_i) begin
         if (full_o)
            err_o <= 1'b1;
         else
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ctrblk_gen.sv
module ctrblk_gen
   import ctrblk_pkg::*;
#(
   parameter int BLK_W  = 128,
   parameter int WORD_W = 32,
   parameter int CW0    = 32,
   parameter int CW1    = 64,
   parameter int CW2    = 128,
   parameter int CW3    = 192,
   parameter int INT_W  = 16,
   parameter int GAL_W  = 32,
   parameter longint unsigned GAL_LIMIT = 64'd4294967294,
   localparam int NWORDS = BLK_W / WORD_W,
   localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iv_wr_i,
   input  logic [IDX_W-1:0]  iv_idx_i,
   input  logic [WORD_W-1:0] iv_data_i,
   input  logic [1:0]        mode_i,
   input  logic [1:0]        wsel_i,
   input  logic              start_i,
   input  logic              adv_i,
   output logic [BLK_W-1:0]  blk_o,
   output logic              valid_o,
   output logic              wrap_o,
   output logic              err_o
);
   if (BLK_W % WORD_W != 0) begin : g_bad_words
      $error("BLK_W must be a multiple of WORD_W");
   end
   if (INT_W < 1 || GAL_W < 1 || CW0 < 1 || CW1 < 1 || CW2 < 1 || CW3 < 1) begin : g_bad_width
      $error("counter widths must be positive");
   end
   if (GAL_LIMIT < 1) begin : g_bad_limit
      $error("GAL_LIMIT must be at least one");
   end

   logic [BLK_W-1:0] iv_w;
   logic [BLK_W-1:0] act_mask;
   logic [BLK_W-1:0] nxt_w;
   logic             roll_w;
   logic             full_w;
   ctr_cfg_t         cfg_q;
   logic             is_gal;
   logic             step_ok;
   logic             held;

   ctrblk_iv_stage #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_iv (
      .clk(clk), .rst_n(rst_n), .wr_i(iv_wr_i), .idx_i(iv_idx_i),
      .data_i(iv_data_i), .iv_o(iv_w)
   );

   ctrblk_width_sel #(
      .BLK_W(BLK_W), .CW0(CW0), .CW1(CW1), .CW2(CW2), .CW3(CW3),
      .INT_W(INT_W), .GAL_W(GAL_W)
   ) u_wsel (
      .cfg_i(cfg_q), .mask_o(act_mask)
   );

   ctrblk_incr #(.BLK_W(BLK_W)) u_inc (
      .cur_i(blk_o), .mask_i(act_mask), .nxt_o(nxt_w), .roll_o(roll_w)
   );

   assign is_gal  = (cfg_q.mode == CTRM_GAL);
   assign step_ok = valid_o && adv_i && !start_i;
   assign held    = is_gal && (full_w || err_o);

   ctrblk_limit #(.LIMIT(GAL_LIMIT)) u_lim (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .step_i(step_ok && is_gal), .full_o(full_w), .err_o(err_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_o   <= '0;
         valid_o <= 1'b0;
         wrap_o  <= 1'b0;
         cfg_q   <= '{mode: CTRM_GEN, wsel: 2'd0};
      end else if (start_i) begin
         blk_o   <= iv_w;
         valid_o <= 1'b1;
         wrap_o  <= 1'b0;
         cfg_q   <= '{mode: ctr_mode_e'(mode_i), wsel: wsel_i};
      end else if (step_ok && !held) begin
         blk_o  <= nxt_w;
         wrap_o <= roll_w;
      end else begin
         wrap_o <= 1'b0;
      end
   end
endmodule

// File: rtl/ctrblk_gen_chk.sv
module ctrblk_gen_chk #(
   parameter int BLK_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             adv_i,
   input logic [BLK_W-1:0] blk_o,
   input logic             valid_o,
   input logic             wrap_o,
   input logic             err_o,
   input logic [BLK_W-1:0] act_mask
);
   assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(valid_o && adv_i && !start_i) |->
         (((blk_o ^ $past(blk_o)) & ~$past(act_mask)) == '0));

   assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> ((blk_o & act_mask) == '0));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> err_o);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> $stable(blk_o));

   assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && !wrap_o && !err_o));
endmodule

bind ctrblk_gen ctrblk_gen_chk #(.BLK_W(BLK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .adv_i(adv_i),
   .blk_o(blk_o), .valid_o(valid_o), .wrap_o(wrap_o), .err_o(err_o),
   .act_mask(act_mask)
);

// File: tb/ctrblk_gen_test.sv
`timescale 1ns/1ps
module ctrblk_gen_test;
   localparam int LIM = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         iv_wr_i = 1'b0;
   logic [1:0]   iv_idx_i = '0;
   logic [31:0]  iv_data_i = '0;
   logic [1:0]   mode_i = '0;
   logic [1:0]   wsel_i = '0;
   logic         start_i = 1'b0;
   logic         adv_i = 1'b0;
   logic [127:0] blk_o;
   logic         valid_o, wrap_o, err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctrblk_gen #(.GAL_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .iv_wr_i(iv_wr_i), .iv_idx_i(iv_idx_i),
      .iv_data_i(iv_data_i), .mode_i(mode_i), .wsel_i(wsel_i),
      .start_i(start_i), .adv_i(adv_i), .blk_o(blk_o), .valid_o(valid_o),
      .wrap_o(wrap_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int width_of(input int md, input int ws);
      if (md == 1) return 16;
      if (md == 2) return 32;
      case (ws)
         0: return 32;
         1: return 64;
         default: return 128;
      endcase
   endfunction

   function automatic logic [127:0] low_ones(input int n);
      if (n >= 128) return '1;
      return (128'd1 << n) - 128'd1;
   endfunction

   task automatic load_iv(input logic [127:0] v);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         iv_wr_i = 1'b1; iv_idx_i = 2'(i); iv_data_i = v[32*i +: 32];
      end
      @(negedge clk);
      iv_wr_i = 1'b0;
   endtask

   task automatic do_start(input int md, input int ws, input bit with_adv);
      @(negedge clk);
      mode_i = 2'(md); wsel_i = 2'(ws); start_i = 1'b1; adv_i = with_adv;
      @(negedge clk);
      start_i = 1'b0; adv_i = 1'b0;
   endtask

   task automatic step;
      @(negedge clk);
      adv_i = 1'b1;
      @(negedge clk);
      adv_i = 1'b0;
   endtask

   task automatic sweep(input int md, input int ws, input logic [127:0] pat, input string req, input int steps);
      int n;
      logic [127:0] lm, cur, iv;
      n  = width_of(md, ws);
      lm = low_ones(n);
      iv = (pat & ~lm) | (lm - 128'd1);
      load_iv(iv);
      do_start(md, ws, 1'b0);
      chk(blk_o === iv && valid_o, "R2", blk_o, iv);
      cur = iv;
      for (int k = 0; k < steps; k++) begin
         logic [127:0] nx;
         bit           wr;
         wr = ((cur & lm) == lm);
         nx = (cur & ~lm) | ((cur + 128'd1) & lm);
         step();
         chk(blk_o === nx, req, blk_o, nx);
         chk(((blk_o ^ iv) & ~lm) == '0, "R7", blk_o, iv);
         chk(wrap_o === wr, "R8", 128'(wrap_o), 128'(wr));
         cur = nx;
      end
      @(negedge clk);
      chk(wrap_o === 1'b0, "R8", 128'(wrap_o), 128'd0);
   endtask

   initial begin
      logic [127:0] pa, pb, iv;
      pa = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;
      pb = ~pa;
      repeat (3) @(negedge clk);
      chk(blk_o === '0 && !valid_o && !wrap_o && !err_o, "R1", blk_o, '0);
      rst_n = 1'b1;

      step();
      chk(blk_o === '0 && !valid_o, "R10", blk_o, '0);

      iv = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
      load_iv(iv);
      chk(blk_o === '0, "R2", blk_o, '0);
      do_start(0, 0, 1'b0);
      chk(blk_o === iv && valid_o && !wrap_o && !err_o, "R2", blk_o, iv);

      for (int ws = 0; ws < 3; ws++) sweep(0, ws, pa, "R3", 4);
      sweep(0, 0, pb, "R3", 3);
      sweep(0, 1, pb, "R3", 3);
      sweep(3, 1, pa, "R3", 3);
      sweep(0, 3, pa, "R4", 4);
      for (int ws = 0; ws < 4; ws++) sweep(1, ws, pa, "R5", 4);
      for (int ws = 0; ws < 4; ws++) sweep(2, ws, pb, "R6", LIM - 1);

      iv = 128'h0;
      load_iv(iv);
      do_start(2, 1, 1'b0);
      for (int k = 1; k < LIM; k++) step();
      chk(blk_o === 128'(LIM - 1) && !err_o, "R9", blk_o, 128'(LIM - 1));
      step();
      chk(err_o === 1'b1, "R9", 128'(err_o), 128'd1);
      chk(blk_o === 128'(LIM - 1), "R9", blk_o, 128'(LIM - 1));
      step();
      chk(err_o === 1'b1 && blk_o === 128'(LIM - 1), "R9", blk_o, 128'(LIM - 1));
      do_start(2, 1, 1'b0);
      chk(err_o === 1'b0 && blk_o === iv, "R9", 128'(err_o), 128'd0);

      iv = 128'h0000_0000_0000_0000_0000_0000_0000_0007;
      load_iv(iv);
      do_start(0, 0, 1'b1);
      chk(blk_o === iv && valid_o, "R11", blk_o, iv);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule